// File: doc/BRIEF.md
# Bitwise Region Match Unit

This unit scores how two records relate, given one occurrence word for each. Every bit of a 32-bit operand marks one contiguous region of a record. A bit is set when a search term appears in that region. The unit takes two such words, A and B, and produces three kinds of mask.

- **Overlap mask:** the regions where both terms appear.
- **Similarity mask:** the regions where the two words agree.
- **Neighbour masks:** the regions set in A whose immediate neighbour is set in B. There is one mask for the lower neighbour and one for the upper neighbour, plus their union.

Two population counts come with the masks as scalar scores. One counts the overlap mask and the other counts the similarity mask.

A caller presents both words with a one-cycle valid strobe. One clock later, every mask and count appears on registered outputs together with a valid flag. The output registers load only on a valid strobe. Between results they keep the last result, so a slow consumer can read them at leisure.

Top module: `region_match_unit`

## Requirements
- R1: `overlap_mask` equals A AND B, where A and B are the words captured with the strobe.
- R2: `similar_mask` has a 1 in every bit position where A and B carry the same value, and a 0 where they differ.
- R3: `left_mask` equals A AND (B shifted one place toward bit 31). Bit 0 of the shifted word is zero, and B's bit 31 is dropped, so the shift does not wrap around.
- R4: `right_mask` equals A AND (B shifted one place toward bit 0). Bit 31 of the shifted word is zero, and B's bit 0 is dropped, so the shift does not wrap around.
- R5: `adjacent_mask` is the bitwise OR of `left_mask` and `right_mask`. It never has a bit set where A is clear.
- R6: `overlap_count` is the number of ones in `overlap_mask`, as an unsigned 6-bit value from 0 to 32.
- R7: `similar_count` is the number of ones in `similar_mask`, as an unsigned 6-bit value from 0 to 32.
- R8: `out_valid` is high in the cycle after a clock edge that sampled `in_valid` high, and low in the cycle after an edge that sampled it low.
- R9: A synchronous active-high `rst` clears `out_valid`, every mask and both counts to zero.
- R10: A clock edge that samples `in_valid` low leaves every mask and count output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe; A and B are captured on edges where it is high |
| a_word | input | 32 | Occurrence word A |
| b_word | input | 32 | Occurrence word B |
| out_valid | output | 1 | High for one cycle per accepted operand pair |
| overlap_mask | output | 32 | Regions where both words are set |
| similar_mask | output | 32 | Regions where the words agree |
| left_mask | output | 32 | A bits whose lower neighbour is set in B |
| right_mask | output | 32 | A bits whose upper neighbour is set in B |
| adjacent_mask | output | 32 | Union of `left_mask` and `right_mask` |
| overlap_count | output | 6 | Ones count of `overlap_mask` |
| similar_count | output | 6 | Ones count of `similar_mask` |

## Verification
The properties rely on two assumptions about the inputs. The first is that `a_word` and `b_word` are stable and known on every edge where `in_valid` is high. The second is that `rst` is held for at least one edge before results are judged. The stimulus meets both by changing all inputs on the falling clock edge and by holding reset for several cycles both at start-up and in mid-run. Strobes come in back-to-back bursts and with idle gaps, which exercises both the one-cycle valid timing and the hold behaviour. Operand pairs with set bits at positions 0 and 31 probe the zero-fill at both ends of the neighbour shifts.

// File: rtl/rmu_pkg.sv
package rmu_pkg;

    // Operand width: one bit per record region.
    parameter int RMU_W = 32;
    // Count width large enough to hold the value RMU_W itself.
    localparam int RMU_CW = $clog2(RMU_W + 1);

    typedef logic [RMU_W-1:0]  mask_t;
    typedef logic [RMU_CW-1:0] count_t;

    // Complete registered result of one comparison.
    typedef struct packed {
        logic   valid;
        mask_t  overlap;
        mask_t  similar;
        mask_t  left_nb;
        mask_t  right_nb;
        mask_t  adjacent;
        count_t ovl_cnt;
        count_t sim_cnt;
    } rmu_result_t;

endpackage

// File: rtl/rmu_mask_logic.sv
module rmu_mask_logic
    import rmu_pkg::*;
#(
    parameter int W = RMU_W
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] overlap,
    output logic [W-1:0] similar,
    output logic [W-1:0] left_nb,
    output logic [W-1:0] right_nb,
    output logic [W-1:0] adjacent
);

    // B moved one region up and one region down, zero-filled at the ends.
    logic [W-1:0] b_up;
    logic [W-1:0] b_dn;

    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_shift
            if (g == 0) begin : g_lo_edge
                assign b_up[g] = 1'b0;
            end else begin : g_lo_body
                assign b_up[g] = op_b[g-1];
            end
            if (g == W - 1) begin : g_hi_edge
                assign b_dn[g] = 1'b0;
            end else begin : g_hi_body
                assign b_dn[g] = op_b[g+1];
            end
        end
    endgenerate

    always_comb begin
        overlap  = op_a & op_b;
        similar  = ~(op_a ^ op_b);
        left_nb  = op_a & b_up;
        right_nb = op_a & b_dn;
        adjacent = left_nb | right_nb;
    end

endmodule

// File: rtl/rmu_popcount.sv
module rmu_popcount
    import rmu_pkg::*;
#(
    parameter int W  = RMU_W,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_in,
    output logic [CW-1:0] ones
);

    // Count in nibbles first, then add the nibble counts.
    localparam int NIB   = 4;
    localparam int NCH   = (W + NIB - 1) / NIB;
    localparam int PAD_W = NCH * NIB;

    logic [PAD_W-1:0] padded;
    logic [2:0]       part [NCH];

    assign padded = PAD_W'(bits_in);

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_nib
            assign part[c] = {2'b00, padded[c*NIB]}
                           + {2'b00, padded[c*NIB+1]}
                           + {2'b00, padded[c*NIB+2]}
                           + {2'b00, padded[c*NIB+3]};
        end
    endgenerate

    always_comb begin
        ones = '0;
        for (int i = 0; i < NCH; i++) begin
            ones = ones + CW'(part[i]);
        end
    end

endmodule

// File: rtl/region_match_unit.sv
module region_match_unit
    import rmu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [RMU_W-1:0]  a_word,
    input  logic [RMU_W-1:0]  b_word,
    output logic              out_valid,
    output logic [RMU_W-1:0]  overlap_mask,
    output logic [RMU_W-1:0]  similar_mask,
    output logic [RMU_W-1:0]  left_mask,
    output logic [RMU_W-1:0]  right_mask,
    output logic [RMU_W-1:0]  adjacent_mask,
    output logic [RMU_CW-1:0] overlap_count,
    output logic [RMU_CW-1:0] similar_count
);

    localparam int W  = RMU_W;
    localparam int CW = RMU_CW;

    mask_t  ovl_c;
    mask_t  sim_c;
    mask_t  lft_c;
    mask_t  rgt_c;
    mask_t  adj_c;
    count_t ovl_cnt_c;
    count_t sim_cnt_c;

    rmu_result_t res_d;
    rmu_result_t res_q;

    rmu_mask_logic #(.W(W)) i_masks (
        .op_a     (a_word),
        .op_b     (b_word),
        .overlap  (ovl_c),
        .similar  (sim_c),
        .left_nb  (lft_c),
        .right_nb (rgt_c),
        .adjacent (adj_c)
    );

    rmu_popcount #(.W(W), .CW(CW)) i_ovl_count (
        .bits_in (ovl_c),
        .ones    (ovl_cnt_c)
    );

    rmu_popcount #(.W(W), .CW(CW)) i_sim_count (
        .bits_in (sim_c),
        .ones    (sim_cnt_c)
    );

    // Next-state: load a fresh result on a strobe, otherwise keep the data.
    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.overlap  = ovl_c;
            res_d.similar  = sim_c;
            res_d.left_nb  = lft_c;
            res_d.right_nb = rgt_c;
            res_d.adjacent = adj_c;
            res_d.ovl_cnt  = ovl_cnt_c;
            res_d.sim_cnt  = sim_cnt_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid     = res_q.valid;
    assign overlap_mask  = res_q.overlap;
    assign similar_mask  = res_q.similar;
    assign left_mask     = res_q.left_nb;
    assign right_mask    = res_q.right_nb;
    assign adjacent_mask = res_q.adjacent;
    assign overlap_count = res_q.ovl_cnt;
    assign similar_count = res_q.sim_cnt;

    // ---------------- assertions ----------------
    p_overlap_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> overlap_mask == ($past(a_word) & $past(b_word)));

    p_similar_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (similar_mask ^ $past(a_word) ^ $past(b_word)) == {W{1'b1}});

    p_left_r3: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> left_mask == ($past(a_word) & ($past(b_word) << 1)));

    p_right_r4: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> right_mask == ($past(a_word) & ($past(b_word) >> 1)));

    p_adj_within_a_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (adjacent_mask & ~$past(a_word)) == '0);

    p_ovl_count_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (overlap_count == CW'($countones(overlap_mask))
                       && overlap_count <= CW'(W)));

    p_sim_count_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> similar_count == CW'($countones(similar_mask)));

    p_valid_rise_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_fall_r8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(overlap_mask) && $stable(similar_mask)
                       && $stable(adjacent_mask) && $stable(overlap_count)
                       && $stable(similar_count)));

endmodule

// File: tb/test_region_match_unit.sv
`timescale 1ns/1ps
module test_region_match_unit;
    import rmu_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] a_word = '0;
    logic [31:0] b_word = '0;
    logic        out_valid;
    logic [31:0] overlap_mask, similar_mask, left_mask, right_mask, adjacent_mask;
    logic [5:0]  overlap_count, similar_count;

    int checks = 0;
    int fails  = 0;
    bit mon_en = 1'b0;
    bit done   = 1'b0;
    logic prev_in_valid = 1'b0;

    rmu_result_t exp_q[$];
    rmu_result_t last_seen = '0;

    always #4 clk = ~clk;   // 125 MHz

    region_match_unit i_region_match_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .a_word(a_word), .b_word(b_word), .out_valid(out_valid),
        .overlap_mask(overlap_mask), .similar_mask(similar_mask),
        .left_mask(left_mask), .right_mask(right_mask),
        .adjacent_mask(adjacent_mask),
        .overlap_count(overlap_count), .similar_count(similar_count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic rmu_result_t model(input logic [31:0] a, input logic [31:0] b);
        rmu_result_t r;
        r.valid    = 1'b1;
        r.overlap  = a & b;
        r.similar  = ~(a ^ b);
        r.left_nb  = a & {b[30:0], 1'b0};
        r.right_nb = a & {1'b0, b[31:1]};
        r.adjacent = r.left_nb | r.right_nb;
        r.ovl_cnt  = 6'($countones(r.overlap));
        r.sim_cnt  = 6'($countones(r.similar));
        return r;
    endfunction

    task automatic compare_all(input rmu_result_t e, input string tag);
        check(overlap_mask  == e.overlap,  "R1",  {tag, " overlap"},  overlap_mask,  e.overlap);
        check(similar_mask  == e.similar,  "R2",  {tag, " similar"},  similar_mask,  e.similar);
        check(left_mask     == e.left_nb,  "R3",  {tag, " left"},     left_mask,     e.left_nb);
        check(right_mask    == e.right_nb, "R4",  {tag, " right"},    right_mask,    e.right_nb);
        check(adjacent_mask == e.adjacent, "R5",  {tag, " adjacent"}, adjacent_mask, e.adjacent);
        check(overlap_count == e.ovl_cnt,  "R6",  {tag, " ovl_cnt"},  32'(overlap_count), 32'(e.ovl_cnt));
        check(similar_count == e.sim_cnt,  "R7",  {tag, " sim_cnt"},  32'(similar_count), 32'(e.sim_cnt));
    endtask

    // Driver: one operand pair per call, inputs change on the falling edge.
    task automatic drive(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        a_word   = a;
        b_word   = b;
        in_valid = 1'b1;
        exp_q.push_back(model(a, b));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            a_word   = ~a_word;   // junk that must be ignored (R10)
            b_word   = b_word ^ 32'h5A5A_0F0F;
        end
    endtask

    always @(posedge clk) prev_in_valid <= rst ? 1'b0 : in_valid;

    // Monitor: compares registered outputs half a cycle after each edge.
    always @(negedge clk) begin
        if (mon_en && !rst) begin
            check(out_valid == prev_in_valid, "R8", "out_valid timing",
                  32'(out_valid), 32'(prev_in_valid));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "result without expectation", 32'd1, 32'd0);
                end else begin
                    rmu_result_t e;
                    e = exp_q.pop_front();
                    compare_all(e, "result");
                    last_seen = e;
                end
            end else begin
                compare_all(last_seen, "hold R10");
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf_a;
        logic [31:0] lf_b;
        lf_a = 32'hACE1_2468;
        lf_b = 32'h1357_9BDF;

        repeat (3) @(negedge clk);
        // R9: reset state
        check(out_valid == 1'b0 && overlap_mask == '0 && similar_mask == '0 &&
              adjacent_mask == '0 && overlap_count == '0 && similar_count == '0,
              "R9", "reset state", {overlap_mask[15:0], 10'd0, similar_count}, 32'd0);
        rst = 1'b0;
        mon_en = 1'b1;

        // Distinct patterns and shift boundaries (R1..R7)
        drive(32'h0000_0000, 32'h0000_0000);   // similar all ones, sim_cnt 32
        drive(32'hFFFF_FFFF, 32'hFFFF_FFFF);   // overlap count 32
        drive(32'hAAAA_AAAA, 32'h5555_5555);   // overlap 0, neighbours everywhere
        idle(2);
        drive(32'h8000_0000, 32'h0000_0001);   // R3/R4: no wrap around
        drive(32'h0000_0001, 32'h8000_0000);   // R3/R4: no wrap around
        drive(32'h8000_0000, 32'h4000_0000);   // R3: left match at bit 31
        drive(32'h0000_0001, 32'h0000_0002);   // R4: right match at bit 0
        idle(3);
        drive(32'h0F0F_00FF, 32'h00FF_0F0F);
        for (int k = 0; k < 40; k++) begin
            lf_a = {lf_a[30:0], lf_a[31] ^ lf_a[21] ^ lf_a[1] ^ lf_a[0]};
            lf_b = {lf_b[30:0], lf_b[31] ^ lf_b[21] ^ lf_b[1] ^ lf_b[0]};
            drive(lf_a, lf_b);
            if (k % 7 == 3) idle(1);
        end
        idle(3);

        // R9: reset in mid-run, right after a strobe
        drive(32'h1234_5678, 32'hFFFF_0000);
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        mon_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && overlap_mask == '0 && left_mask == '0 &&
              right_mask == '0 && overlap_count == '0 && similar_count == '0,
              "R9", "mid-run reset", overlap_mask, 32'd0);
        exp_q.delete();
        last_seen = '0;
        rst = 1'b0;
        mon_en = 1'b1;
        idle(2);
        drive(32'hC000_0003, 32'h6000_0006);
        idle(2);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule